// File: doc/BRIEF.md
# External and pin-change interrupt unit

This block turns pin activity into interrupt requests for a small microcontroller. It watches one dedicated external interrupt pin and eighteen pin-change inputs. The pin-change inputs fall into three unevenly sized groups. Each group has its own enable mask and one sticky flag. The flag is set when any enabled pin in the group changes level. The dedicated pin has a selectable sense mode: low level, falling edge, rising edge, or any change.

Every pin passes through a two-flop synchronizer. Edges and toggles are found by comparing the synchronized value with the sample taken one cycle earlier. Detection works from the pin level whatever the pin's direction, so software can raise an interrupt by driving a pin that is configured as an output. Each request output is gated by its own source enable and by a global disable. Neither gate clears the flag behind the request.

A separate combinational wake output compares the live pin levels with the last sampled values, so a change on an enabled pin-change input is seen even while the clock is stopped.

Top module: `xirq_unit`

## Requirements
- R1: Pin-change inputs 0 to 7 feed group 0, inputs 8 to 11 feed group 1 and inputs 12 to 17 feed group 2. Group g drives `grp_req[g]`, and a pin only ever sets the flag of its own group.
- R2: A change of an enabled pin-change input, in either direction, sets its group flag. The change shows on `grp_req` after the third rising clock edge that follows it.
- R3: A pin whose bit is 0 in its group's mask (`pc_mask0` bit i covers pin i, `pc_mask1` bit i covers pin 8+i, `pc_mask2` bit i covers pin 12+i) never sets a group flag.
- R4: In the edge sense modes, a matching edge on `ext_pin` sets a sticky flag, shown on `ext_req` after the third rising edge. The `ext_sense` encodings are 2'b10 for falling, 2'b11 for rising and 2'b01 for any change. An edge that does not match the mode has no effect.
- R5: With `ext_sense` = 2'b00 (low level), `ext_req` is high from the second rising edge after `ext_pin` goes low until the second rising edge after it returns high. Nothing is latched.
- R6: A flag stays set until a one-cycle clear strobe (`ext_clr`, `grp_clr[g]`). The strobe clears the flag at the next edge. If an event arrives in the same cycle as the strobe, the flag stays set.
- R7: Each request is its flag (or low level) ANDed with its source enable (`ext_en`, `grp_en[g]`). Disabling the source hides the request but keeps the flag.
- R8: While `all_off` is 1, every request output is 0. The flags are kept and reappear once `all_off` returns to 0.
- R9: Reset clears all flags and requests. The synchronizers reset to all ones, so pins that are idle high produce no event after reset.
- R10: `wake` is high, with no clock edge needed, whenever an enabled pin-change input differs from its last sampled value. A masked pin never drives `wake`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pc_pin | input | 18 | Asynchronous pin-change inputs |
| ext_pin | input | 1 | Asynchronous dedicated interrupt pin |
| pc_mask0 | input | 8 | Enable mask for group 0 |
| pc_mask1 | input | 4 | Enable mask for group 1 |
| pc_mask2 | input | 6 | Enable mask for group 2 |
| ext_sense | input | 2 | Sense mode of the dedicated pin |
| ext_en | input | 1 | Request enable for the dedicated pin |
| grp_en | input | 3 | Request enable per pin-change group |
| all_off | input | 1 | Global request disable |
| ext_clr | input | 1 | Clear strobe for the dedicated-pin flag |
| grp_clr | input | 3 | Clear strobes for the group flags |
| ext_req | output | 1 | Dedicated-pin interrupt request |
| grp_req | output | 3 | Pin-change group interrupt requests |
| wake | output | 1 | Combinational wake indication |

## Verification
The hardest case to reach from the ports is a clear strobe that lands in the same cycle as a new event. The event is visible inside the block for exactly one cycle, between the second and third edges after the pin moves. The bench moves a pin and counts two edges, then raises the clear for the following cycle and checks that the flag survives. Mask gating is covered with a table of pin patterns that toggle masked and unmasked pins across all three groups.

// File: rtl/xirq_pkg.sv
package xirq_pkg;

    typedef enum logic [1:0] {
        SENSE_LOW  = 2'b00,
        SENSE_ANY  = 2'b01,
        SENSE_FALL = 2'b10,
        SENSE_RISE = 2'b11
    } sense_e;

    localparam int NGRP = 3;

endpackage

// File: rtl/xirq_sync.sv
module xirq_sync #(
    parameter int W = 19
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] cur,
    output logic [W-1:0] prev
);

    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
        logic [W-1:0] old;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.s1  = din;
        st_d.s2  = st_q.s1;
        st_d.old = st_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '1;
        else        st_q <= st_d;
    end

    assign cur  = st_q.s2;
    assign prev = st_q.old;

endmodule

// File: rtl/xirq_group.sv
module xirq_group #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cur,
    input  logic [W-1:0] prev,
    input  logic [W-1:0] mask,
    input  logic         clr,
    output logic         flag
);

    typedef struct packed {
        logic flag;
    } grp_st_t;

    grp_st_t st_d, st_q;
    logic    hit;

    always_comb begin
        hit       = |((cur ^ prev) & mask);
        st_d      = st_q;
        st_d.flag = (st_q.flag & ~clr) | hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag = st_q.flag;

endmodule

// File: rtl/xirq_ext.sv
module xirq_ext
    import xirq_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   cur,
    input  logic   prev,
    input  sense_e sense,
    input  logic   clr,
    output logic   flag,
    output logic   level_on
);

    typedef struct packed {
        logic flag;
    } ext_st_t;

    ext_st_t st_d, st_q;
    logic    fall, rise, evt;

    always_comb begin
        fall = prev & ~cur;
        rise = ~prev & cur;
        unique case (sense)
            SENSE_ANY:  evt = fall | rise;
            SENSE_FALL: evt = fall;
            SENSE_RISE: evt = rise;
            default:    evt = 1'b0;
        endcase
        st_d      = st_q;
        st_d.flag = (st_q.flag & ~clr) | evt;
        level_on  = (sense == SENSE_LOW) & ~cur;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag = st_q.flag;

endmodule

// File: rtl/xirq_unit.sv
module xirq_unit
    import xirq_pkg::*;
#(
    parameter int G0_W = 8,
    parameter int G1_W = 4,
    parameter int G2_W = 6,
    localparam int NPC = G0_W + G1_W + G2_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPC-1:0]  pc_pin,
    input  logic            ext_pin,
    input  logic [G0_W-1:0] pc_mask0,
    input  logic [G1_W-1:0] pc_mask1,
    input  logic [G2_W-1:0] pc_mask2,
    input  logic [1:0]      ext_sense,
    input  logic            ext_en,
    input  logic [NGRP-1:0] grp_en,
    input  logic            all_off,
    input  logic            ext_clr,
    input  logic [NGRP-1:0] grp_clr,
    output logic            ext_req,
    output logic [NGRP-1:0] grp_req,
    output logic            wake
);

    localparam int NSYNC = NPC + 1;

    logic [NSYNC-1:0] sync_cur, sync_prev;
    logic [NPC-1:0]   pc_cur, pc_prev, mask_all;
    logic             ext_cur, ext_prev;
    logic [NGRP-1:0]  grp_flag;
    logic             ext_flag, ext_level;
    sense_e           sense;

    assign mask_all = {pc_mask2, pc_mask1, pc_mask0};
    assign sense    = sense_e'(ext_sense);

    xirq_sync #(.W(NSYNC)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({ext_pin, pc_pin}),
        .cur  (sync_cur),
        .prev (sync_prev)
    );

    assign pc_cur   = sync_cur[NPC-1:0];
    assign pc_prev  = sync_prev[NPC-1:0];
    assign ext_cur  = sync_cur[NPC];
    assign ext_prev = sync_prev[NPC];

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        localparam int LO = (g == 0) ? 0 : ((g == 1) ? G0_W : G0_W + G1_W);
        localparam int GW = (g == 0) ? G0_W : ((g == 1) ? G1_W : G2_W);
        xirq_group #(.W(GW)) u_grp (
            .clk  (clk),
            .rst_n(rst_n),
            .cur  (pc_cur[LO +: GW]),
            .prev (pc_prev[LO +: GW]),
            .mask (mask_all[LO +: GW]),
            .clr  (grp_clr[g]),
            .flag (grp_flag[g])
        );
    end

    xirq_ext u_ext (
        .clk     (clk),
        .rst_n   (rst_n),
        .cur     (ext_cur),
        .prev    (ext_prev),
        .sense   (sense),
        .clr     (ext_clr),
        .flag    (ext_flag),
        .level_on(ext_level)
    );

    always_comb begin
        grp_req = all_off ? '0 : (grp_flag & grp_en);
        ext_req = ((sense == SENSE_LOW) ? ext_level : ext_flag) & ext_en & ~all_off;
        wake    = |((pc_pin ^ pc_prev) & mask_all);
    end

endmodule

// File: rtl/xirq_chk.sv
module xirq_chk #(
    parameter int G0_W = 8,
    parameter int G1_W = 4,
    parameter int G2_W = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic            all_off,
    input logic            ext_en,
    input logic [1:0]      ext_sense,
    input logic            ext_cur,
    input logic            ext_req,
    input logic [2:0]      grp_flag,
    input logic [2:0]      grp_clr,
    input logic [2:0]      grp_en,
    input logic [2:0]      grp_req,
    input logic [G0_W-1:0] pc_mask0,
    input logic [G1_W-1:0] pc_mask1,
    input logic [G2_W-1:0] pc_mask2
);

    logic [2:0] m_any;
    assign m_any = {|pc_mask2, |pc_mask1, |pc_mask0};

    AST_GATE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        all_off |-> (grp_req == 3'b000 && !ext_req)); // R8

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(grp_flag) & ~$past(grp_clr) & ~grp_flag) == 3'b000)); // R6

    AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        ((~$past(grp_flag) & ~$past(m_any) & grp_flag) == 3'b000)); // R3

    AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_sense == 2'b00 && ext_en && !all_off && !ext_cur) |-> ext_req); // R5

    AST_REQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        ((grp_req & ~(grp_flag & grp_en)) == 3'b000)); // R7

endmodule

bind xirq_unit xirq_chk #(.G0_W(G0_W), .G1_W(G1_W), .G2_W(G2_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .all_off  (all_off),
    .ext_en   (ext_en),
    .ext_sense(ext_sense),
    .ext_cur  (ext_cur),
    .ext_req  (ext_req),
    .grp_flag (grp_flag),
    .grp_clr  (grp_clr),
    .grp_en   (grp_en),
    .grp_req  (grp_req),
    .pc_mask0 (pc_mask0),
    .pc_mask1 (pc_mask1),
    .pc_mask2 (pc_mask2)
);

// File: tb/test_xirq_unit.sv
`timescale 1ns/1ps
module test_xirq_unit;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [17:0] pc_pin;
    logic        ext_pin;
    logic [7:0]  pc_mask0;
    logic [3:0]  pc_mask1;
    logic [5:0]  pc_mask2;
    logic [1:0]  ext_sense;
    logic        ext_en, all_off, ext_clr;
    logic [2:0]  grp_en, grp_clr;
    logic        ext_req, wake;
    logic [2:0]  grp_req;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    xirq_unit i_xirq_unit (
        .clk(clk), .rst_n(rst_n), .pc_pin(pc_pin), .ext_pin(ext_pin),
        .pc_mask0(pc_mask0), .pc_mask1(pc_mask1), .pc_mask2(pc_mask2),
        .ext_sense(ext_sense), .ext_en(ext_en), .grp_en(grp_en),
        .all_off(all_off), .ext_clr(ext_clr), .grp_clr(grp_clr),
        .ext_req(ext_req), .grp_req(grp_req), .wake(wake)
    );

    typedef struct packed {
        logic [17:0] pins;
        logic [2:0]  exp;
    } vec_t;

    // masks: group0 = 8'hF0, group1 = 4'b0011, group2 = 6'h3F
    localparam vec_t VEC [9] = '{
        '{18'h3FFFE, 3'b000},  // pin 0 masked (R3)
        '{18'h3FFEE, 3'b001},  // pin 4 -> group 0
        '{18'h3FEEE, 3'b010},  // pin 8 -> group 1
        '{18'h3F6EE, 3'b000},  // pin 11 masked
        '{18'h1F6EE, 3'b100},  // pin 17 -> group 2
        '{18'h1E6CE, 3'b101},  // pins 5 and 12
        '{18'h1E4CF, 3'b010},  // pin 0 masked, pin 9 enabled
        '{18'h1E4CF, 3'b000},  // no change
        '{18'h3FFFF, 3'b111}   // several pins in every group, rising
    };

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse_clr(logic e, logic [2:0] g);
        ext_clr = e;
        grp_clr = g;
        tick(1);
        ext_clr = 1'b0;
        grp_clr = 3'b000;
    endtask

    initial begin
        rst_n = 1'b0; pc_pin = '1; ext_pin = 1'b1;
        pc_mask0 = '0; pc_mask1 = '0; pc_mask2 = '0;
        ext_sense = 2'b00; ext_en = 1'b1; grp_en = 3'b000;
        all_off = 1'b0; ext_clr = 1'b0; grp_clr = 3'b000;
        repeat (4) @(negedge clk);
        chk("R9 reset grp_req", grp_req, 0);
        chk("R9 reset ext_req", ext_req, 0);
        chk("R9 reset wake", wake, 0);
        rst_n = 1'b1;
        pc_mask0 = 8'hF0; pc_mask1 = 4'b0011; pc_mask2 = 6'h3F; grp_en = 3'b111;
        tick(3);
        chk("R9 quiet after reset", {ext_req, grp_req}, 0);

        // table walk: R1 R2 R3
        foreach (VEC[i]) begin
            pc_pin = VEC[i].pins;
            tick(3);
            chk($sformatf("R1 R2 R3 vector %0d", i), grp_req, VEC[i].exp);
            pulse_clr(1'b0, 3'b111);
            chk($sformatf("R6 cleared after vector %0d", i), grp_req, 0);
        end

        // R2 timing: not visible after two edges
        pc_pin[4] = 1'b0;
        tick(2);
        chk("R2 not before third edge", grp_req, 0);
        tick(1);
        chk("R2 falling toggle", grp_req, 3'b001);
        tick(5);
        chk("R6 sticky", grp_req, 3'b001);
        pulse_clr(1'b0, 3'b001);
        chk("R6 clear", grp_req, 0);

        // R6 event in same cycle as clear
        pc_pin[4] = 1'b1;
        tick(2);
        grp_clr = 3'b001;
        tick(1);
        grp_clr = 3'b000;
        chk("R6 event beats clear", grp_req, 3'b001);

        // R7 and R8
        grp_en = 3'b110;
        #1 chk("R7 source disabled", grp_req, 0);
        grp_en = 3'b111;
        #1 chk("R7 flag kept", grp_req, 3'b001);
        all_off = 1'b1;
        #1 chk("R8 global off", grp_req, 0);
        all_off = 1'b0;
        #1 chk("R8 flag kept", grp_req, 3'b001);
        tick(0);
        pulse_clr(1'b0, 3'b111);

        // R10 wake
        pc_pin[6] = 1'b0;
        #1 chk("R10 wake without edge", wake, 1);
        tick(3);
        chk("R10 wake drops once sampled", wake, 0);
        pc_pin[1] = 1'b0;
        #1 chk("R10 masked pin no wake", wake, 0);
        tick(3);
        pulse_clr(1'b0, 3'b111);

        // R4 edge modes
        ext_sense = 2'b11;
        ext_pin = 1'b0;
        tick(3);
        chk("R4 rise mode ignores fall", ext_req, 0);
        ext_pin = 1'b1;
        tick(2);
        chk("R4 rise not before third edge", ext_req, 0);
        tick(1);
        chk("R4 rise", ext_req, 1);
        pulse_clr(1'b1, 3'b000);
        chk("R6 ext clear", ext_req, 0);
        ext_sense = 2'b10;
        ext_pin = 1'b0;
        tick(3);
        chk("R4 fall", ext_req, 1);
        pulse_clr(1'b1, 3'b000);
        ext_pin = 1'b1;
        tick(3);
        chk("R4 fall mode ignores rise", ext_req, 0);
        ext_sense = 2'b01;
        ext_pin = 1'b0;
        tick(3);
        chk("R4 any change fall", ext_req, 1);
        pulse_clr(1'b1, 3'b000);
        ext_pin = 1'b1;
        tick(3);
        chk("R4 any change rise", ext_req, 1);
        pulse_clr(1'b1, 3'b000);

        // R5 low level
        ext_sense = 2'b00;
        #1 chk("R5 high pin no request", ext_req, 0);
        ext_pin = 1'b0;
        tick(1);
        chk("R5 not after one edge", ext_req, 0);
        tick(1);
        chk("R5 low level", ext_req, 1);
        tick(6);
        chk("R5 held while low", ext_req, 1);
        ext_en = 1'b0;
        #1 chk("R7 ext disabled", ext_req, 0);
        ext_en = 1'b1;
        ext_pin = 1'b1;
        tick(1);
        chk("R5 still low in sync", ext_req, 1);
        tick(1);
        chk("R5 no latch", ext_req, 0);

        // R9 reset in mid-run
        pc_pin[4] = 1'b0;
        tick(3);
        chk("R9 flag before reset", grp_req, 3'b001);
        pc_pin = '1;
        rst_n = 1'b0;
        tick(1);
        rst_n = 1'b1;
        tick(4);
        chk("R9 reset clears flag", grp_req, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule